// File: doc/BRIEF.md
# Multi-Channel DAC Serial Command Port

This block is the digital front end of a sixteen-channel, multi-range converter. It listens on a four-wire serial port as a slave. Each transaction is a 24-bit frame made of a command byte and a 16-bit data word. The block decodes the command and updates a register bank:

- per-channel staging ("input") codes and active ("DAC") codes,
- a one-shot output-range code,
- four dither control registers: power-down, polarity, source map and scale map.

All serial inputs are sampled by the system clock, which must run well above the serial clock. Edges are found inside the block.

The active codes and all configuration registers leave the block as parallel, registered outputs. Downstream converter logic consumes them directly. A host reads a channel back in two frames. The first frame names the channel. During the next frame, that channel's active code is shifted out on `sdo`.

Top module: `spi_dac_ctrl`

## Requirements
- R1: After `rst`, the following hold:
  - every active code reads 0 and the range code reads 0;
  - polarity, source and scale maps read 0 and every dither power-down bit reads 1;
  - `sdo` is 0 and readback output is enabled.
- R2: A frame is bits 23..0 sent MSB first on `mosi` while `cs_n` is low:
  - bits 23:16 are the command and bits 15:0 the data word;
  - `mosi` is sampled on rising `sclk` and `sdo` changes after falling `sclk`;
  - a frame that ends with any bit count other than 24 changes nothing;
  - registers change only after `cs_n` rises.
- R3: Command 0x2n loads channel n's active code with the data word. Command 0x1n loads only channel n's staging code and leaves the active outputs unchanged.
- R4: Command 0x30 copies every staging code into its channel's active code in one step.
- R5: Command 0x60 loads every active code with the data word and leaves the staging codes unchanged.
- R6: Command 0x40 loads the range code from data bits 2:0. Only the first such write after a reset is accepted, and later ones are ignored until the next reset.
- R7: Command 0x51 loads the dither power-down register (bit n for channel n, 1 = off). Command 0xB0 loads the dither polarity register (bit n, 1 = inverted).
- R8: The 32-bit source map and the 32-bit scale map hold two bits per channel, at bits 2n+1:2n. Scale codes are 0 = x1, 1 = x0.75, 2 = x0.5 and 3 = x0.25. The half-load commands are:
  - 0x90 loads source bits 15:0 and 0xA0 loads source bits 31:16;
  - 0xC0 loads scale bits 15:0 and 0xD0 loads scale bits 31:16.
- R9: Command 0x70 with data word 0x1234 restores the full reset state of R1. Command 0x70 with any other word leaves every register unchanged.
- R10: After command 0x8n, the next frame drives `sdo` with zeros for bits 23:16 and then channel n's active code, MSB first, for bits 15:0. The value is taken when that frame starts. `sdo` is 0 between frames and in frames not preceded by a readback command.
- R11: Command 0x01 with data bit 0 = 1 mutes `sdo` (all zeros during readback). The same command with bit 0 = 0 unmutes it.
- R12: `hw_rst` high for a clock edge restores the R1 state and discards any frame in progress. A full frame started after it falls is accepted.
- R13: Frames whose command is none of the above change nothing and do not change a pending readback. Examples are 0x02, 0x35, 0x41, 0x52, 0xE0 and 0xF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_rst | input | 1 | Active-high device reset pin, synchronous to clk |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data in |
| sdo | output | 1 | Serial readback data out |
| dac_codes | output | NCH*16 | Active codes, channel n at bits 16n+15:16n |
| span_code | output | SPW | Output range code |
| dith_pwr | output | NCH | Dither power-down, 1 = off |
| dith_inv | output | NCH | Dither polarity, 1 = inverted |
| dith_src | output | 2*NCH | Dither source map |
| dith_scl | output | 2*NCH | Dither scale map |

## Verification
The case of interest is the device reset pin rising in the same clock in which a frame's chip-select release would commit a write. The bench raises `hw_rst` at the instant `cs_n` goes high after a complete 24-bit write. It then expects the reset state, with the write lost.

A second overlap is also checked: a channel write arriving in the frame that is busy shifting out that same channel's readback. The bench expects the old code on `sdo` and the new code on the outputs afterwards.

A behavioural model in the bench is compared against every output on every idle clock.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  localparam int FRAME_BITS = 24;
  localparam int OP_BITS    = 8;
  localparam int WORD_BITS  = 16;
  localparam logic [WORD_BITS-1:0] RESET_KEY = 16'h1234;

  typedef enum logic [4:0] {
    OP_NONE, OP_NOP, OP_SDO, OP_IN, OP_DAC, OP_LOAD, OP_SPAN, OP_PWR,
    OP_ALL, OP_SRST, OP_READ, OP_SRC_LO, OP_SRC_HI, OP_INV, OP_SCL_LO, OP_SCL_HI
  } op_e;

  typedef struct packed {
    op_e                  op;
    logic [3:0]           ch;
    logic [WORD_BITS-1:0] word;
  } cmd_t;

  function automatic op_e op_of(input logic [OP_BITS-1:0] c);
    op_e r;
    r = OP_NONE;
    case (c[7:4])
      4'h0: begin
        if (c[3:0] == 4'h0) r = OP_NOP;
        else if (c[3:0] == 4'h1) r = OP_SDO;
      end
      4'h1: r = OP_IN;
      4'h2: r = OP_DAC;
      4'h3: if (c[3:0] == 4'h0) r = OP_LOAD;
      4'h4: if (c[3:0] == 4'h0) r = OP_SPAN;
      4'h5: if (c[3:0] == 4'h1) r = OP_PWR;
      4'h6: if (c[3:0] == 4'h0) r = OP_ALL;
      4'h7: if (c[3:0] == 4'h0) r = OP_SRST;
      4'h8: r = OP_READ;
      4'h9: if (c[3:0] == 4'h0) r = OP_SRC_LO;
      4'hA: if (c[3:0] == 4'h0) r = OP_SRC_HI;
      4'hB: if (c[3:0] == 4'h0) r = OP_INV;
      4'hC: if (c[3:0] == 4'h0) r = OP_SCL_LO;
      4'hD: if (c[3:0] == 4'h0) r = OP_SCL_HI;
      default: r = OP_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dacif_rx.sv
module dacif_rx
  import dacif_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  mosi,
  input  logic [WORD_BITS-1:0]  load_word,
  output logic                  frame_ok,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  sdo
);

  localparam int CNTW = $clog2(FRAME_BITS + 2);
  localparam int PADW = FRAME_BITS - WORD_BITS;

  logic sclk_r, sclk_p, cs_r, cs_p, mosi_r;
  logic rise, fall, f_start, f_end;
  logic [CNTW-1:0]       cnt;
  logic [FRAME_BITS-1:0] sh;
  logic [FRAME_BITS-1:0] tx;

  // Pin sampling and edge detection in the system clock domain
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_r <= 1'b0;
      sclk_p <= 1'b0;
      cs_r   <= 1'b1;
      cs_p   <= 1'b1;
      mosi_r <= 1'b0;
    end else begin
      sclk_r <= sclk;
      sclk_p <= sclk_r;
      cs_r   <= cs_n;
      cs_p   <= cs_r;
      mosi_r <= mosi;
    end
  end

  assign rise    =  sclk_r & ~sclk_p;
  assign fall    = ~sclk_r &  sclk_p;
  assign f_start = ~cs_r   &  cs_p;
  assign f_end   =  cs_r   & ~cs_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      frame    <= '0;
      frame_ok <= 1'b0;
    end else begin
      frame_ok <= 1'b0;
      if (f_start) begin
        cnt <= '0;
        tx  <= {{PADW{1'b0}}, load_word};
      end else if (f_end) begin
        frame_ok <= (cnt == CNTW'(FRAME_BITS));
        frame    <= sh;
        tx       <= '0;
      end else if (!cs_r) begin
        if (rise) begin
          sh <= {sh[FRAME_BITS-2:0], mosi_r};
          if (cnt != '1) cnt <= cnt + 1'b1;
        end
        if (fall) tx <= {tx[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  assign sdo = tx[FRAME_BITS-1];

endmodule

// File: rtl/dacif_decode.sv
module dacif_decode
  import dacif_pkg::*;
#(
  parameter int NCH = 16
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_ok,
  input  logic [FRAME_BITS-1:0] frame,
  output logic                  cmd_vld,
  output cmd_t                  cmd
);

  op_e        op_c;
  logic [3:0] ch_c;
  logic       chan_bad;

  assign op_c     = op_of(frame[FRAME_BITS-1 -: OP_BITS]);
  assign ch_c     = frame[WORD_BITS +: 4];
  assign chan_bad = (op_c == OP_IN || op_c == OP_DAC || op_c == OP_READ) &&
                    (int'(ch_c) >= NCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_vld  <= 1'b0;
      cmd.op   <= OP_NONE;
      cmd.ch   <= '0;
      cmd.word <= '0;
    end else begin
      cmd_vld  <= frame_ok && (op_c != OP_NONE) && !chan_bad;
      cmd.op   <= op_c;
      cmd.ch   <= ch_c;
      cmd.word <= frame[WORD_BITS-1:0];
    end
  end

endmodule

// File: rtl/dacif_bank.sv
module dacif_bank
  import dacif_pkg::*;
#(
  parameter int NCH = 16,
  parameter int SPW = 3
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_vld,
  input  cmd_t                     cmd,
  output logic [NCH*WORD_BITS-1:0] dac_codes,
  output logic [SPW-1:0]           span_code,
  output logic [NCH-1:0]           dith_pwr,
  output logic [NCH-1:0]           dith_inv,
  output logic [2*NCH-1:0]         dith_src,
  output logic [2*NCH-1:0]         dith_scl,
  output logic [WORD_BITS-1:0]     rb_word
);

  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int MAPW = 2 * NCH;

  logic           wipe;
  logic           span_open;
  logic           armed;
  logic           sdo_en;
  logic [CHW-1:0] rb_ch;

  assign wipe = rst | (cmd_vld && cmd.op == OP_SRST && cmd.word == RESET_KEY);

  function automatic logic [MAPW-1:0] put_half(input logic [MAPW-1:0] m,
                                               input logic [WORD_BITS-1:0] w,
                                               input logic hi);
    logic [MAPW-1:0] r;
    r = m;
    for (int i = 0; i < MAPW; i++) begin
      if ((i >= WORD_BITS) == hi) r[i] = w[i % WORD_BITS];
    end
    return r;
  endfunction

  // Per-channel staging and active code registers
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [WORD_BITS-1:0] in_r;
    logic [WORD_BITS-1:0] dac_r;
    logic                 hit;

    assign hit = (cmd.ch == 4'(g));

    always_ff @(posedge clk) begin
      if (wipe) begin
        in_r  <= '0;
        dac_r <= '0;
      end else if (cmd_vld) begin
        if (cmd.op == OP_IN && hit) in_r <= cmd.word;
        if ((cmd.op == OP_DAC && hit) || cmd.op == OP_ALL) dac_r <= cmd.word;
        else if (cmd.op == OP_LOAD) dac_r <= in_r;
      end
    end

    assign dac_codes[g*WORD_BITS +: WORD_BITS] = dac_r;
  end

  // Configuration, dither and readback control
  always_ff @(posedge clk) begin
    if (wipe) begin
      span_code <= '0;
      span_open <= 1'b1;
      dith_pwr  <= '1;
      dith_inv  <= '0;
      dith_src  <= '0;
      dith_scl  <= '0;
      armed     <= 1'b0;
      rb_ch     <= '0;
      sdo_en    <= 1'b1;
    end else if (cmd_vld) begin
      armed <= (cmd.op == OP_READ);
      if (cmd.op == OP_READ) rb_ch <= cmd.ch[CHW-1:0];
      case (cmd.op)
        OP_SDO:    sdo_en <= ~cmd.word[0];
        OP_SPAN: begin
          if (span_open) begin
            span_code <= cmd.word[SPW-1:0];
            span_open <= 1'b0;
          end
        end
        OP_PWR:    dith_pwr <= cmd.word[NCH-1:0];
        OP_INV:    dith_inv <= cmd.word[NCH-1:0];
        OP_SRC_LO: dith_src <= put_half(dith_src, cmd.word, 1'b0);
        OP_SRC_HI: dith_src <= put_half(dith_src, cmd.word, 1'b1);
        OP_SCL_LO: dith_scl <= put_half(dith_scl, cmd.word, 1'b0);
        OP_SCL_HI: dith_scl <= put_half(dith_scl, cmd.word, 1'b1);
        default: ;
      endcase
    end
  end

  assign rb_word = (armed && sdo_en) ? dac_codes[rb_ch*WORD_BITS +: WORD_BITS] : '0;

endmodule

// File: rtl/spi_dac_ctrl.sv
module spi_dac_ctrl
  import dacif_pkg::*;
#(
  parameter int NCH = 16,
  parameter int SPW = 3
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hw_rst,
  input  logic                     sclk,
  input  logic                     cs_n,
  input  logic                     mosi,
  output logic                     sdo,
  output logic [NCH*WORD_BITS-1:0] dac_codes,
  output logic [SPW-1:0]           span_code,
  output logic [NCH-1:0]           dith_pwr,
  output logic [NCH-1:0]           dith_inv,
  output logic [2*NCH-1:0]         dith_src,
  output logic [2*NCH-1:0]         dith_scl
);

  logic                  any_rst;
  logic                  frame_ok;
  logic [FRAME_BITS-1:0] frame;
  logic                  cmd_vld;
  cmd_t                  cmd;
  logic [WORD_BITS-1:0]  rb_word;

  assign any_rst = rst | hw_rst;

  dacif_rx u_rx (
    .clk(clk), .rst(any_rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .load_word(rb_word), .frame_ok(frame_ok), .frame(frame), .sdo(sdo)
  );

  dacif_decode #(.NCH(NCH)) u_dec (
    .clk(clk), .rst(any_rst), .frame_ok(frame_ok), .frame(frame),
    .cmd_vld(cmd_vld), .cmd(cmd)
  );

  dacif_bank #(.NCH(NCH), .SPW(SPW)) u_bank (
    .clk(clk), .rst(any_rst), .cmd_vld(cmd_vld), .cmd(cmd),
    .dac_codes(dac_codes), .span_code(span_code), .dith_pwr(dith_pwr),
    .dith_inv(dith_inv), .dith_src(dith_src), .dith_scl(dith_scl),
    .rb_word(rb_word)
  );

endmodule

// File: rtl/spi_dac_ctrl_chk.sv
module spi_dac_ctrl_chk #(
  parameter int NCH = 16,
  parameter int SPW = 3
)(
  input logic                clk,
  input logic                rst,
  input logic                hw_rst,
  input logic                cs_n,
  input logic                sdo,
  input logic [NCH*16-1:0]   dac_codes,
  input logic [SPW-1:0]      span_code,
  input logic [NCH-1:0]      dith_pwr
);

  // R1
  rst_state_chk: assert property (@(posedge clk) disable iff (hw_rst)
    rst |=> (dac_codes == '0 && span_code == '0 && dith_pwr == '1 && !sdo));

  // R12
  pin_reset_chk: assert property (@(posedge clk) disable iff (rst)
    hw_rst |=> (dac_codes == '0 && span_code == '0 && dith_pwr == '1));

  // R2
  no_midframe_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n) && !$past(cs_n, 2) && !$past(cs_n, 3) &&
     !$past(cs_n, 4) && !$past(cs_n, 5) && !hw_rst && !$past(hw_rst))
    |-> $stable(dac_codes));

  // R6
  span_once_chk: assert property (@(posedge clk) disable iff (rst)
    (span_code != '0) |=> (span_code == $past(span_code) || span_code == '0));

  // R10
  sdo_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo);

endmodule

bind spi_dac_ctrl spi_dac_ctrl_chk #(.NCH(NCH), .SPW(SPW)) u_chk (
  .clk(clk), .rst(rst), .hw_rst(hw_rst), .cs_n(cs_n), .sdo(sdo),
  .dac_codes(dac_codes), .span_code(span_code), .dith_pwr(dith_pwr)
);

// File: tb/sim_spi_dac_ctrl.sv
module sim_spi_dac_ctrl;
  localparam int NCH = 16;
  localparam int SPW = 3;

  logic clk = 1'b0, rst = 1'b1, hw_rst = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic                sdo;
  logic [NCH*16-1:0]   dac_codes;
  logic [SPW-1:0]      span_code;
  logic [NCH-1:0]      dith_pwr, dith_inv;
  logic [2*NCH-1:0]    dith_src, dith_scl;

  always #5 clk = ~clk;

  spi_dac_ctrl #(.NCH(NCH), .SPW(SPW)) u0 (
    .clk(clk), .rst(rst), .hw_rst(hw_rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .sdo(sdo), .dac_codes(dac_codes), .span_code(span_code), .dith_pwr(dith_pwr),
    .dith_inv(dith_inv), .dith_src(dith_src), .dith_scl(dith_scl)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    busy = 1'b1;
  bit    done = 1'b0;

  // Behavioural reference state
  logic [15:0] m_dac [16];
  logic [15:0] m_in  [16];
  logic [2:0]  m_span;
  bit          m_span_open;
  logic [15:0] m_pwr, m_inv;
  logic [31:0] m_src, m_scl;
  bit          m_arm, m_sdo_en;
  int          m_ch;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin m_dac[i] = '0; m_in[i] = '0; end
    m_span = '0; m_span_open = 1'b1; m_pwr = 16'hFFFF; m_inv = '0;
    m_src = '0; m_scl = '0; m_arm = 1'b0; m_ch = 0; m_sdo_en = 1'b1;
  endtask

  task automatic model_apply(input logic [7:0] c, input logic [15:0] d);
    bit known = 1'b1;
    bit lo0 = (c[3:0] == 4'h0);
    int n = int'(c[3:0]);
    case (c[7:4])
      4'h0: if (c == 8'h01) m_sdo_en = !d[0]; else if (c != 8'h00) known = 1'b0;
      4'h1: m_in[n] = d;
      4'h2: m_dac[n] = d;
      4'h3: if (lo0) for (int i = 0; i < 16; i++) m_dac[i] = m_in[i]; else known = 1'b0;
      4'h4: if (lo0) begin if (m_span_open) begin m_span = d[2:0]; m_span_open = 1'b0; end end
            else known = 1'b0;
      4'h5: if (c[3:0] == 4'h1) m_pwr = d; else known = 1'b0;
      4'h6: if (lo0) for (int i = 0; i < 16; i++) m_dac[i] = d; else known = 1'b0;
      4'h7: if (lo0) begin if (d == 16'h1234) model_reset(); end else known = 1'b0;
      4'h8: ;
      4'h9: if (lo0) m_src[15:0]  = d; else known = 1'b0;
      4'hA: if (lo0) m_src[31:16] = d; else known = 1'b0;
      4'hB: if (lo0) m_inv = d; else known = 1'b0;
      4'hC: if (lo0) m_scl[15:0]  = d; else known = 1'b0;
      4'hD: if (lo0) m_scl[31:16] = d; else known = 1'b0;
      default: known = 1'b0;
    endcase
    if (known) begin
      m_arm = (c[7:4] == 4'h8);
      if (m_arm) m_ch = n;
    end
  endtask

  function automatic logic [NCH*16-1:0] exp_dac();
    logic [NCH*16-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*16 +: 16] = m_dac[i];
    return v;
  endfunction

  // Compare all parallel outputs with the model on every idle clock
  always @(negedge clk) begin
    if (!busy && !rst && !done) begin
      logic [NCH*16+3+16+16+32+32-1:0] got, exp;
      got = {dac_codes, span_code, dith_pwr, dith_inv, dith_src, dith_scl};
      exp = {exp_dac(), m_span, m_pwr, m_inv, m_src, m_scl};
      n_cmp++;
      if (got !== exp) begin
        n_bad++;
        $display("FAIL %s outputs got %h exp %h", cur_req, got, exp);
      end
    end
  end

  task automatic send(input logic [7:0] c, input logic [15:0] d,
                      input int nbits = 24, input bit hw_hit = 1'b0);
    logic [23:0] f, got, exp_sdo;
    f = {c, d};
    got = '0;
    exp_sdo = (m_arm && m_sdo_en) ? {8'h00, m_dac[m_ch]} : 24'h0;
    cs_n = 1'b0;
    tick(4);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 24) ? f[23-i] : 1'b0;
      tick(4);
      if (i < 24) got[23-i] = sdo;
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
    end
    tick(4);
    busy = 1'b1;
    cs_n = 1'b1;
    if (hw_hit) hw_rst = 1'b1;
    tick(3);
    hw_rst = 1'b0;
    tick(8);
    if (hw_hit) model_reset();
    else if (nbits == 24) model_apply(c, d);
    busy = 1'b0;
    if (nbits == 24 && !hw_hit) begin
      n_cmp++;
      if (got !== exp_sdo) begin
        n_bad++;
        $display("FAIL %s sdo got %h exp %h", cur_req, got, exp_sdo);
      end
    end
    tick(4);
  endtask

  task automatic pin_reset();
    busy = 1'b1;
    hw_rst = 1'b1;
    tick(3);
    hw_rst = 1'b0;
    model_reset();
    tick(2);
    busy = 1'b0;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    model_reset();
    tick(4);
    rst = 1'b0;
    tick(1);
    busy = 1'b0;
    cur_req = "R1"; tick(6);                                   // reset state
    cur_req = "R3"; send(8'h23, 16'hA5A5); send(8'h17, 16'h1234);
    cur_req = "R4"; send(8'h10, 16'h0101); send(8'h30, 16'h0);
    cur_req = "R5"; send(8'h60, 16'h7777); send(8'h30, 16'h0);
    cur_req = "R6"; send(8'h40, 16'h0006); send(8'h40, 16'h0007);
    cur_req = "R7"; send(8'h51, 16'h00F0); send(8'hB0, 16'h8001);
    cur_req = "R8"; send(8'h90, 16'h1234); send(8'hA0, 16'hFFFF);
                    send(8'hC0, 16'h00AA); send(8'hD0, 16'h5500);
    cur_req = "R13"; send(8'h52, 16'hFFFF); send(8'h35, 16'h0);
                     send(8'hE0, 16'hFFFF); send(8'h02, 16'h0001);
                     send(8'h41, 16'h0003); send(8'hF0, 16'h1234);
    cur_req = "R2"; send(8'h2F, 16'hFFFF, 23); send(8'h2F, 16'hFFFF, 25);
                    send(8'h2E, 16'h0E0E);
    cur_req = "R10"; send(8'h29, 16'hC3A5); send(8'h89, 16'h0); send(8'h00, 16'h0);
                     send(8'h25, 16'hBEEF); send(8'h85, 16'h0);
                     send(8'h25, 16'h1111); send(8'h00, 16'h0);
    cur_req = "R11"; send(8'h01, 16'h0001); send(8'h89, 16'h0); send(8'h00, 16'h0);
                     send(8'h01, 16'h0000); send(8'h89, 16'h0); send(8'h00, 16'h0);
    cur_req = "R9"; send(8'h70, 16'h1233); send(8'h70, 16'h1234); send(8'h40, 16'h0005);
    cur_req = "R12"; send(8'h22, 16'h2222); pin_reset();
                     send(8'h24, 16'h4444, 24, 1'b1);
                     send(8'h40, 16'h0002); send(8'h24, 16'h4444);
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog %s expired", cur_req);
      report();
      $finish;
    end
  end

endmodule